// File: doc/BRIEF.md
# I2C Bus Clear Sequencer

When a target device on an I2C bus is left holding SDA low, for example because a transfer was cut off part-way through a byte, the controller cannot issue a new transaction. This sequencer frees the bus. A start pulse launches a fixed recovery pattern. SDA is left released, so the stuck target sees a not-acknowledge. SCL is then clocked low and high a fixed number of times, nine by default. The sequence closes with a proper STOP condition.

Both lines are open-drain. The block only ever asks for a line to be pulled low or released; it never drives a line high. The length of each SCL phase is set by a half-period count in system clock cycles, so a recovery clock of about 25 kHz (a 20 µs half-period) comes from the system clock frequency alone. After a release, a high phase is timed only once SCL actually reads back high, which honours clock stretching by the target. Before signalling completion, the block also waits until SDA reads back high.

Top module: `i2c_bus_clear`

## Requirements
- R1: When `start` is high at a clock edge while the block is idle, `busy` and `scl_pull` are both high in the following cycle.
- R2: Each sequence contains exactly PULSES (default 9) SCL low phases before the STOP phases begin.
- R3: Every SCL low phase lasts H cycles, where H equals `half_ticks`, or 1 when `half_ticks` is 0.
- R4: `sda_pull` stays low (SDA released, a not-acknowledge level) throughout the whole pulse burst.
- R5: A high phase counts H consecutive cycles in which `scl_in` reads high. Cycles in which the released SCL still reads low extend the phase.
- R6: After the last pulse, both lines are pulled low for H cycles. SCL is then released while SDA stays pulled for H high cycles. Finally SDA is released while SCL is high, which forms a STOP.
- R7: When SCL and SDA both read high after the release, the sequence ends. In the cycle where `busy` falls, `done` is high for exactly one cycle. With no stretching, `busy` lasts 20·H+1 cycles.
- R8: A `start` pulse that arrives while `busy` is high is ignored, and the sequence timing is unchanged.
- R9: After reset, `busy`, `done`, `scl_pull` and `sda_pull` are all low. A high output on a pull port means "pull the line low"; a low output means "release".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_ticks | input | TICK_W | Half-period of the recovery clock in clock cycles (0 acts as 1) |
| start | input | 1 | Launch a recovery sequence when idle |
| scl_in | input | 1 | Sampled level of the SCL line |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The assertions check on every cycle the properties that hold whatever the timing:
- SDA only changes while SCL is low, or is released while SCL is high, so no false START ever appears.
- A stretched high phase never advances.
- `done` is a single-cycle pulse that coincides with `busy` falling.
- STOP only follows the last counted pulse.
- The pulse counter never exceeds its bound.

Only the bench's scenarios can show the exact phase lengths, the pulse count of nine, and the total sequence duration under each half-period. They also show how a stretch delays the timing, and that a start arriving mid-sequence leaves the waveform unchanged.

// File: rtl/bclr_pkg.sv
package bclr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_STOP_LOW,
        ST_STOP_HIGH,
        ST_RELEASE
    } bclr_state_e;

    typedef struct packed {
        bclr_state_e state;
        logic        done;
    } bclr_regs_t;

endpackage

// File: rtl/bclr_timer.sv
module bclr_timer #(
    parameter int TICK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [TICK_W-1:0] limit_m1,
    output logic              expire
);
    localparam logic [TICK_W-1:0] ONE = TICK_W'(1);

    logic [TICK_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = en && (cnt_q >= limit_m1);
        cnt_d  = cnt_q;
        if (clr || expire) cnt_d = '0;
        else if (en)       cnt_d = cnt_q + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TIMER_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0)); // R3

endmodule

// File: rtl/bclr_pulse_count.sv
module bclr_pulse_count #(
    parameter int PULSES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int              CNT_W  = (PULSES > 1) ? $clog2(PULSES) : 1;
    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(PULSES - 1);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + ONE;
        last = (cnt_q == LAST_V);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_V); // R2

endmodule

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear #(
    parameter int TICK_W = 16,
    parameter int PULSES = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TICK_W-1:0] half_ticks,
    input  logic              start,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_pull,
    output logic              sda_pull,
    output logic              busy,
    output logic              done
);
    import bclr_pkg::*;

    localparam logic [TICK_W-1:0] ONE = TICK_W'(1);

    bclr_regs_t        r_d, r_q;
    logic [TICK_W-1:0] limit_m1;
    logic              t_clr, t_en, t_expire;
    logic              p_clr, p_inc, p_last;

    assign limit_m1 = (half_ticks == '0) ? '0 : (half_ticks - ONE);

    bclr_timer #(.TICK_W(TICK_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (t_clr),
        .en       (t_en),
        .limit_m1 (limit_m1),
        .expire   (t_expire)
    );

    bclr_pulse_count #(.PULSES(PULSES)) u_pulses (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (p_clr),
        .inc   (p_inc),
        .last  (p_last)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        t_clr    = 1'b0;
        t_en     = 1'b0;
        p_clr    = 1'b0;
        p_inc    = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                t_clr = 1'b1;
                p_clr = 1'b1;
                if (start) r_d.state = ST_LOW;
            end
            ST_LOW: begin
                t_en = 1'b1;
                if (t_expire) r_d.state = ST_HIGH;
            end
            ST_HIGH: begin
                t_en  = scl_in;
                t_clr = !scl_in;
                if (t_expire) begin
                    if (p_last) begin
                        p_clr     = 1'b1;
                        r_d.state = ST_STOP_LOW;
                    end else begin
                        p_inc     = 1'b1;
                        r_d.state = ST_LOW;
                    end
                end
            end
            ST_STOP_LOW: begin
                t_en = 1'b1;
                if (t_expire) r_d.state = ST_STOP_HIGH;
            end
            ST_STOP_HIGH: begin
                t_en  = scl_in;
                t_clr = !scl_in;
                if (t_expire) r_d.state = ST_RELEASE;
            end
            ST_RELEASE: begin
                t_clr = 1'b1;
                if (sda_in && scl_in) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign scl_pull = (r_q.state == ST_LOW) || (r_q.state == ST_STOP_LOW);
    assign sda_pull = (r_q.state == ST_STOP_LOW) || (r_q.state == ST_STOP_HIGH);
    assign busy     = (r_q.state != ST_IDLE);
    assign done     = r_q.done;

    AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && scl_pull)); // R1
    AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_HIGH && !scl_in) |=> (r_q.state == ST_HIGH)); // R5
    AST_SDA_PULL_UNDER_LOW_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> scl_pull); // R6
    AST_SDA_FREE_IS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull) |-> !scl_pull); // R6
    AST_STOP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> $past(p_last)); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R7

endmodule

// File: tb/tb_i2c_bus_clear.sv
module tb_i2c_bus_clear;
    localparam int TICK_W = 16;
    localparam int PULSES = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [TICK_W-1:0] half_ticks = '0;
    logic              start = 1'b0;
    logic              stretch = 1'b0;
    logic              scl_in, sda_in;
    logic              scl_pull, sda_pull, busy, done;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    int st [PULSES+1];
    int rel, lows, cyc, ign_at;
    logic prev_low;

    always #10 clk = ~clk;

    // open-drain bus model with optional target clock stretching
    assign scl_in = !scl_pull && !stretch;
    assign sda_in = !sda_pull;

    i2c_bus_clear #(.TICK_W(TICK_W), .PULSES(PULSES)) dut (
        .clk(clk), .rst_n(rst_n), .half_ticks(half_ticks), .start(start),
        .scl_in(scl_in), .sda_in(sda_in), .scl_pull(scl_pull),
        .sda_pull(sda_pull), .busy(busy), .done(done)
    );

    function automatic int eff_half(input int h);
        return (h == 0) ? 1 : h;
    endfunction

    task automatic expect_cycle(input logic e_scl, input logic e_sda,
                                input logic e_busy, input logic e_done,
                                input string tag);
        @(negedge clk);
        checks++;
        if (scl_pull !== e_scl || sda_pull !== e_sda || busy !== e_busy || done !== e_done) begin
            errors++;
            $display("FAIL %s cycle %0d: actual scl=%b sda=%b busy=%b done=%b expected scl=%b sda=%b busy=%b done=%b",
                     tag, cyc, scl_pull, sda_pull, busy, done, e_scl, e_sda, e_busy, e_done);
        end
        if (scl_pull) begin
            if (!prev_low) lows++;
            rel = 0;
            stretch = 1'b0;
        end else begin
            stretch = busy && (lows > 0) && (lows <= PULSES + 1) && (rel < st[lows-1]);
            rel++;
        end
        prev_low = scl_pull;
        start = (cyc == ign_at);
        cyc++;
    endtask

    task automatic run_seq(input int h, input int ign);
        int hh;
        hh = eff_half(h);
        @(negedge clk);
        half_ticks = TICK_W'(h);
        start = 1'b1;
        lows = 0; rel = 0; prev_low = 1'b0; cyc = 0; ign_at = ign;
        for (int k = 0; k < PULSES; k++) begin
            for (int i = 0; i < hh; i++)
                expect_cycle(1'b1, 1'b0, 1'b1, 1'b0, (k == 0 && i == 0) ? "R1 launch" : "R2 R3 R4 R8 low phase");
            for (int i = 0; i < st[k]; i++)
                expect_cycle(1'b0, 1'b0, 1'b1, 1'b0, "R5 stretched high");
            for (int i = 0; i < hh; i++)
                expect_cycle(1'b0, 1'b0, 1'b1, 1'b0, "R4 R5 R8 high phase");
        end
        for (int i = 0; i < hh; i++)
            expect_cycle(1'b1, 1'b1, 1'b1, 1'b0, "R2 R6 stop low");
        for (int i = 0; i < st[PULSES]; i++)
            expect_cycle(1'b0, 1'b1, 1'b1, 1'b0, "R5 R6 stop stretch");
        for (int i = 0; i < hh; i++)
            expect_cycle(1'b0, 1'b1, 1'b1, 1'b0, "R6 stop high");
        expect_cycle(1'b0, 1'b0, 1'b1, 1'b0, "R6 release");
        expect_cycle(1'b0, 1'b0, 1'b0, 1'b1, "R7 done");
        expect_cycle(1'b0, 1'b0, 1'b0, 1'b0, "R7 idle after done");
    endtask

    task automatic clear_stretch();
        for (int i = 0; i <= PULSES; i++) st[i] = 0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        clear_stretch();
        repeat (3) @(negedge clk);
        checks++;
        if (scl_pull !== 1'b0 || sda_pull !== 1'b0 || busy !== 1'b0 || done !== 1'b0) begin
            errors++;
            $display("FAIL R9 in reset: actual %b%b%b%b expected 0000", scl_pull, sda_pull, busy, done);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        checks++;
        if (scl_pull !== 1'b0 || sda_pull !== 1'b0 || busy !== 1'b0 || done !== 1'b0) begin
            errors++;
            $display("FAIL R9 after reset: actual %b%b%b%b expected 0000", scl_pull, sda_pull, busy, done);
        end
        // directed: plain burst, zero half period treated as one, stop-phase stretch
        run_seq(3, -1);
        run_seq(0, -1);
        st[PULSES] = 3;
        st[0] = 2;
        run_seq(2, 5);      // R8 start arrives mid sequence
        clear_stretch();
        run_seq(1, 1);      // R8 start during the very first phase
        // random
        for (int n = 0; n < 8; n++) begin
            for (int i = 0; i <= PULSES; i++)
                st[i] = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 4)) : 0;
            run_seq(int'($urandom_range(1, 6)), int'($urandom_range(2, 60)));
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R7 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule